// File: doc/BRIEF.md
# Event Counter Bank

A bank of event counters that sits beside a processor core and is reached through a narrow register read/write port. The core supplies a vector of single-cycle event strobes, one per counter. Each strobe may also carry a double-weight flag, for events such as a split memory access that must count as two. A counter advances only when its own strobe, its own enable bit and the bank-wide run bit are all high.

Two control registers govern the whole bank. A mode register holds the bank-wide run bit and the choice between clamping at the largest value and rolling over to zero. An enable register holds one gate bit per counter. Software can read and write every counter. One reserved counter address loads the same value into every counter in a single write. It is write-only and reads as zero.

Reads are combinational: read data follows the address in the same cycle while the request is high. Writes take effect at the next rising clock edge.

Top module: `evtcnt_bank`

## Requirements
- R1: After reset the mode register reads 0x0000_0003, the enable register reads 0 and every counter reads 0.
- R2: The mode register at address 0x7A1 has the run bit at bit 0 and the clamp bit at bit 1. Both bits are writable, and every other bit reads as 0.
- R3: The enable register at address 0x7A0 holds bit i as the gate of counter i. Bits at or above the number of implemented counters read as 0.
- R4: Counter i sits at address 0x780+i and reads back the last value written to it.
- R5: In a cycle where event strobe i, enable bit i and the run bit are all 1, counter i advances by 1, or by 2 when its double-weight flag is set. Counters whose enable bit is 0 do not change.
- R6: While the run bit is 0, no counter changes in response to events.
- R7: With the clamp bit set, a counter that would exceed 0xFFFF_FFFF holds 0xFFFF_FFFF.
- R8: With the clamp bit clear, counters roll over modulo 2^32: 0xFFFF_FFFF+1 gives 0, and 0xFFFF_FFFF+2 gives 1.
- R9: A write to address 0x79F loads the written value into every implemented counter. A read of 0x79F returns 0.
- R10: A register write to a counter in the same cycle as its event takes priority, and that event is lost.
- R11: Counter addresses with no implemented counter, other than 0x79F, read as 0, and writes to them change nothing. Unmapped addresses also read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_req_i | input | 1 | Register access request |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, combinational, 0 when no request |
| evt_i | input | NUM_CNT | One-cycle event strobe per counter |
| evt_dbl_i | input | NUM_CNT | Double-weight flag per event strobe |

## Verification
A wrong internal state shows up on the read port on the very next read of the affected register. The read path has no pipeline, so a counter that takes a wrong step is visible one clock after the event. Likewise, a control bit latched wrongly is visible one clock after the write. Faults in the clamp path and the collision path only appear at their boundaries: at the all-ones count, and when a write and an event arrive in the same cycle. The tests therefore place the stimulus at exactly those points and read back immediately.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
   localparam int unsigned CSR_AW  = 12;
   localparam int unsigned IDX_W   = 5;
   localparam int unsigned BCAST_I = 31;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_MODE = 2'd1,
      RSEL_ENA  = 2'd2,
      RSEL_CNT  = 2'd3
   } rsel_e;

   typedef struct packed {
      logic clamp;
      logic run;
   } mode_t;
endpackage

// File: rtl/evtcnt_dec.sv
module evtcnt_dec
   import evtcnt_pkg::*;
#(
   parameter int unsigned            NUM_CNT   = 16,
   parameter logic [CSR_AW-1:0]      CNT_BASE  = 12'h780,
   parameter logic [CSR_AW-1:0]      ENA_ADDR  = 12'h7A0,
   parameter logic [CSR_AW-1:0]      MODE_ADDR = 12'h7A1
) (
   input  logic               req_i,
   input  logic               we_i,
   input  logic [CSR_AW-1:0]  addr_i,
   output logic               wr_mode_o,
   output logic               wr_ena_o,
   output logic [NUM_CNT-1:0] wr_cnt_o,
   output rsel_e              rsel_o,
   output logic [IDX_W-1:0]   ridx_o
);
   localparam int unsigned HI_W = CSR_AW - IDX_W;

   logic             in_cnt;
   logic [IDX_W-1:0] idx;
   logic             is_bcast;
   logic             wr;

   assign in_cnt   = (addr_i[CSR_AW-1:IDX_W] == CNT_BASE[CSR_AW-1:IDX_W]);
   assign idx      = addr_i[IDX_W-1:0];
   assign is_bcast = in_cnt && (idx == IDX_W'(BCAST_I));
   assign wr       = req_i && we_i;

   assign wr_mode_o = wr && (addr_i == MODE_ADDR);
   assign wr_ena_o  = wr && (addr_i == ENA_ADDR);
   assign ridx_o    = idx;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_wsel
      assign wr_cnt_o[i] = wr && in_cnt && (is_bcast || idx == IDX_W'(i));
   end

   always_comb begin
      rsel_o = RSEL_NONE;
      if (req_i && !we_i) begin
         if (addr_i == MODE_ADDR)                                     rsel_o = RSEL_MODE;
         else if (addr_i == ENA_ADDR)                                 rsel_o = RSEL_ENA;
         else if (in_cnt && !is_bcast && 32'(idx) < NUM_CNT)          rsel_o = RSEL_CNT;
      end
   end

   logic unused_hi;
   assign unused_hi = ^HI_W;
endmodule

// File: rtl/evtcnt_cell.sv
module evtcnt_cell #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             evt_i,
   input  logic             dbl_i,
   input  logic             ena_i,
   input  logic             run_i,
   input  logic             clamp_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W:0]   sum;
   logic [CNT_W:0]   step;
   logic             bump;

   assign bump = evt_i && ena_i && run_i;
   assign step = {{(CNT_W-1){1'b0}}, dbl_i, !dbl_i};
   assign sum  = {1'b0, cnt_q} + step;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_i)                        cnt_d = wdata_i;
      else if (bump && sum[CNT_W] && clamp_i) cnt_d = CMAX;
      else if (bump)                   cnt_d = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> cnt_q == $past(wdata_i)); // R10
   AST_HALTED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !wr_i) |=> $stable(cnt_q)); // R6
   AST_GATED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ena_i && !wr_i) |=> $stable(cnt_q)); // R5
   AST_CLAMP_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clamp_i && !wr_i && cnt_q == CMAX) |=> cnt_q == CMAX); // R7
   AST_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clamp_i && !wr_i) |=> cnt_q >= $past(cnt_q)); // R7
endmodule

// File: rtl/evtcnt_bank.sv
module evtcnt_bank
   import evtcnt_pkg::*;
#(
   parameter int unsigned       NUM_CNT   = 16,
   parameter int unsigned       CNT_W     = 32,
   parameter logic [11:0]       CNT_BASE  = 12'h780,
   parameter logic [11:0]       ENA_ADDR  = 12'h7A0,
   parameter logic [11:0]       MODE_ADDR = 12'h7A1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               csr_req_i,
   input  logic               csr_we_i,
   input  logic [11:0]        csr_addr_i,
   input  logic [CNT_W-1:0]   csr_wdata_i,
   output logic [CNT_W-1:0]   csr_rdata_o,
   input  logic [NUM_CNT-1:0] evt_i,
   input  logic [NUM_CNT-1:0] evt_dbl_i
);
   localparam mode_t MODE_RST = '{clamp: 1'b1, run: 1'b1};

   initial begin
      if (NUM_CNT < 1 || NUM_CNT > 31)
         $fatal(1, "NUM_CNT must lie in 1..31");
      if (CNT_W < NUM_CNT || CNT_W < 2)
         $fatal(1, "CNT_W too narrow for enable register");
      if (CNT_BASE[IDX_W-1:0] != '0)
         $fatal(1, "CNT_BASE must be 32-aligned");
   end

   logic               wr_mode, wr_ena;
   logic [NUM_CNT-1:0] wr_cnt;
   rsel_e              rsel;
   logic [IDX_W-1:0]   ridx;
   mode_t              mode_q;
   logic [NUM_CNT-1:0] ena_q;
   logic [CNT_W-1:0]   cnt [NUM_CNT];
   logic [CNT_W-1:0]   cnt_rd;

   evtcnt_dec #(
      .NUM_CNT(NUM_CNT), .CNT_BASE(CNT_BASE),
      .ENA_ADDR(ENA_ADDR), .MODE_ADDR(MODE_ADDR)
   ) i_dec (
      .req_i(csr_req_i), .we_i(csr_we_i), .addr_i(csr_addr_i),
      .wr_mode_o(wr_mode), .wr_ena_o(wr_ena), .wr_cnt_o(wr_cnt),
      .rsel_o(rsel), .ridx_o(ridx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= MODE_RST;
         ena_q  <= '0;
      end else begin
         if (wr_mode) mode_q <= mode_t'(csr_wdata_i[1:0]);
         if (wr_ena)  ena_q  <= csr_wdata_i[NUM_CNT-1:0];
      end
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
      evtcnt_cell #(.CNT_W(CNT_W)) i_cell (
         .clk_i(clk_i), .rst_ni(rst_ni),
         .wr_i(wr_cnt[i]), .wdata_i(csr_wdata_i),
         .evt_i(evt_i[i]), .dbl_i(evt_dbl_i[i]), .ena_i(ena_q[i]),
         .run_i(mode_q.run), .clamp_i(mode_q.clamp),
         .cnt_o(cnt[i])
      );
   end

   always_comb begin
      cnt_rd = '0;
      for (int i = 0; i < NUM_CNT; i++)
         if (ridx == IDX_W'(i)) cnt_rd = cnt[i];
   end

   always_comb begin
      unique case (rsel)
         RSEL_MODE: csr_rdata_o = CNT_W'(mode_q);
         RSEL_ENA:  csr_rdata_o = CNT_W'(ena_q);
         RSEL_CNT:  csr_rdata_o = cnt_rd;
         default:   csr_rdata_o = '0;
      endcase
   end

   AST_BCAST_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && csr_addr_i == CNT_BASE + 12'd31) |-> csr_rdata_o == '0); // R9
   AST_MODE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && !csr_we_i && csr_addr_i == MODE_ADDR) |-> csr_rdata_o[CNT_W-1:2] == '0); // R2
   AST_MODE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_mode |=> mode_q == mode_t'($past(csr_wdata_i[1:0]))); // R2
   AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && csr_we_i && csr_addr_i == CNT_BASE + 12'd31) |-> &wr_cnt); // R9
endmodule

// File: tb/test_evtcnt_bank.sv
module test_evtcnt_bank;
   localparam int NC = 16;
   localparam logic [11:0] CB = 12'h780, EA = 12'h7A0, MA = 12'h7A1;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic [NC-1:0] evt = '0, dbl = '0;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   evtcnt_bank #(.NUM_CNT(NC)) i_evtcnt_bank (
      .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_we_i(we),
      .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
      .evt_i(evt), .evt_dbl_i(dbl)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
      @(negedge clk); req = 0; we = 0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk); req = 1; we = 0; addr = a;
      #1 d = rdata;
      req = 0;
   endtask

   task automatic pulse(logic [NC-1:0] m, logic [NC-1:0] w);
      @(negedge clk); evt = m; dbl = w;
      @(negedge clk); evt = '0; dbl = '0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(MA, v); chk("R1 mode", v, 32'h3);
      rd(EA, v); chk("R1 enable", v, 0);
      rd(CB, v); chk("R1 cnt0", v, 0);
      rd(CB + 15, v); chk("R1 cnt15", v, 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(MA, 32'hFFFF_FFFC); rd(MA, v); chk("R2 mode clear", v, 0);
      wr(MA, 32'hFFFF_FFFF); rd(MA, v); chk("R2 mode set", v, 32'h3);
      wr(EA, 32'hFFFF_FFFF); rd(EA, v); chk("R3 enable width", v, 32'h0000_FFFF);
      wr(CB + 5, 32'hDEAD_BEEF); rd(CB + 5, v); chk("R4 readback", v, 32'hDEAD_BEEF);
      wr(CB + 5, 0);
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr(EA, 32'h5);
      pulse(16'h7, 16'h0);
      rd(CB, v);     chk("R5 cnt0 +1", v, 1);
      rd(CB + 1, v); chk("R5 cnt1 gated", v, 0);
      rd(CB + 2, v); chk("R3 cnt2 +1", v, 1);
      pulse(16'h1, 16'h1);
      rd(CB, v);     chk("R5 cnt0 +2", v, 3);
   endtask

   task automatic t_halt();
      logic [31:0] v;
      wr(MA, 32'h2);
      pulse(16'h5, 16'h0);
      rd(CB, v); chk("R6 halted", v, 3);
      wr(MA, 32'h3);
   endtask

   task automatic t_clamp();
      logic [31:0] v;
      wr(CB, 32'hFFFF_FFFE);
      pulse(16'h1, 16'h1);
      rd(CB, v); chk("R7 reach max", v, 32'hFFFF_FFFF);
      pulse(16'h1, 16'h1);
      rd(CB, v); chk("R7 stay max", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      wr(MA, 32'h1);
      wr(CB, 32'hFFFF_FFFF); pulse(16'h1, 16'h0);
      rd(CB, v); chk("R8 wrap +1", v, 0);
      wr(CB, 32'hFFFF_FFFF); pulse(16'h1, 16'h1);
      rd(CB, v); chk("R8 wrap +2", v, 1);
      wr(MA, 32'h3);
   endtask

   task automatic t_bcast();
      logic [31:0] v;
      wr(CB + 31, 32'h1234);
      rd(CB, v);      chk("R9 cnt0", v, 32'h1234);
      rd(CB + 7, v);  chk("R9 cnt7", v, 32'h1234);
      rd(CB + 15, v); chk("R9 cnt15", v, 32'h1234);
      rd(CB + 31, v); chk("R9 read zero", v, 0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      @(negedge clk); req = 1; we = 1; addr = CB + 2; wdata = 32'h50; evt = 16'h4;
      @(negedge clk); req = 0; we = 0; evt = '0;
      rd(CB + 2, v); chk("R10 write wins", v, 32'h50);
   endtask

   task automatic t_unimpl();
      logic [31:0] v;
      wr(CB + 16, 32'hAA);
      rd(CB + 16, v); chk("R11 unimpl read", v, 0);
      rd(CB, v);      chk("R11 cnt0 untouched", v, 32'h1234);
      rd(12'h7A5, v); chk("R11 unmapped", v, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            t_reset(); t_regs(); t_count(); t_halt(); t_clamp();
            t_wrap(); t_bcast(); t_collide(); t_unimpl();
         end
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule